// File: doc/BRIEF.md
# Packetised Command Receiver with Device ID Filter

This block sits at the command input of a memory device that shares its command bus with other devices and has no select line. Commands arrive as 40-bit packets sent in four 10-bit beats, with a separate start flag raised on the first beat. Each beat is presented as one qualified sample (`beat_vld`) on a beat-rate clock, so the double-edge capture at the pins is handled upstream. The receiver gathers the four beats and compares the 9-bit device ID carried in the packet with the ID this device took from its strap pins when it came out of reset. A packet with a matching ID is delivered as a one-cycle pulse that carries the decoded opcode, burst length, data-clock-pair select and address. A packet addressed to another device is dropped without any indication.

If a start flag arrives before the current packet is complete, the partial packet is thrown away, a one-cycle framing error pulse is raised, and the flagged beat begins a new packet. Beats without the flag that arrive while no packet is open are ignored. Cycles with `beat_vld` low are idle and may fall anywhere, including between the beats of one packet.

Top module: `cmdrx_top`

## Requirements
- R1: While `rst_n` is low, `cmd_vld` and `frame_err` are 0.
- R2: The device ID is taken from `id_strap` on the first clock after reset release. Later changes on `id_strap` have no effect on which packets are accepted.
- R3: A beat with `beat_vld`=1 and `beat_flag`=1 opens a packet and supplies packet bits 39:30. The next three beats with `beat_vld`=1 and `beat_flag`=0 supply bits 29:20, 19:10 and 9:0, in that order.
- R4: When the fourth beat is taken and packet bits 39:31 equal the device ID, `cmd_vld` is 1 for exactly one cycle, in the cycle after the fourth beat.
- R5: With `cmd_vld`=1, `cmd_op` carries packet bits 30:27 and `cmd_addr` carries packet bits 24:0.
- R6: With `cmd_vld`=1, `cmd_blen` is 4 when packet bit 26 is 0 and 8 when it is 1.
- R7: With `cmd_vld`=1, `cmd_dclk` carries packet bit 25, which selects data clock pair 0 or 1.
- R8: A complete packet whose bits 39:31 differ from the device ID produces no `cmd_vld` and no `frame_err`.
- R9: A flagged beat that arrives while one to three beats of a packet are held raises `frame_err` for one cycle, in the cycle after that beat. The partial packet is dropped, and the flagged beat becomes bits 39:30 of a new packet.
- R10: A beat with `beat_flag`=0 that arrives while no packet is open is ignored and does not begin a packet.
- R11: Cycles with `beat_vld`=0 do not advance or disturb packet assembly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Beat-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| id_strap | input | 9 | Device ID strap, sampled once after reset |
| beat_vld | input | 1 | A command beat is present this cycle |
| beat_flag | input | 1 | Start-of-packet flag for this beat |
| beat_data | input | 10 | Command bits of this beat |
| cmd_vld | output | 1 | One-cycle pulse: a packet for this device is complete |
| cmd_op | output | 4 | Decoded opcode |
| cmd_blen | output | 4 | Burst length in words, 4 or 8 |
| cmd_dclk | output | 1 | Data clock pair select |
| cmd_addr | output | 25 | Decoded address |
| frame_err | output | 1 | One-cycle pulse: a partial packet was dropped |

## Verification
Both results come out one cycle after the beat that causes them: `cmd_vld` and the decoded fields in the cycle after the fourth beat, and `frame_err` in the cycle after the early flag. The bench drives beats on the falling edge. A behavioural model, updated on the rising edge from the same inputs, works out what each output must show in the following cycle, and the outputs are compared with it on the next falling edge, half a period after the register update. The decoded fields are compared only in cycles where the model expects a pulse. The ID strap is set up well before reset release and changed only after capture, so its one-cycle capture point is never near a change.

// File: rtl/cmdrx_pkg.sv
package cmdrx_pkg;
  localparam int unsigned BEAT_W  = 10;
  localparam int unsigned N_BEATS = 4;
  localparam int unsigned ID_W    = 9;
  localparam int unsigned OP_W    = 4;
  localparam int unsigned BLEN_W  = 4;
  localparam int unsigned PKT_W   = BEAT_W * N_BEATS;
  localparam int unsigned ADDR_W  = PKT_W - ID_W - OP_W - 2;
  // field positions, top down
  localparam int unsigned ID_LSB  = PKT_W - ID_W;
  localparam int unsigned OP_LSB  = ID_LSB - OP_W;
  localparam int unsigned B8_BIT  = OP_LSB - 1;
  localparam int unsigned DCK_BIT = B8_BIT - 1;
endpackage

// File: rtl/cmdrx_assembler.sv
module cmdrx_assembler
  import cmdrx_pkg::*;
#(
  parameter int unsigned BW = BEAT_W,
  parameter int unsigned NB = N_BEATS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat_vld,
  input  logic             beat_flag,
  input  logic [BW-1:0]    beat_data,
  output logic             pkt_done,
  output logic [BW*NB-1:0] pkt,
  output logic             ferr_set
);
  localparam int unsigned PW    = BW * NB;
  localparam int unsigned HW    = PW - BW;
  localparam int unsigned CW    = (NB > 2) ? $clog2(NB) : 1;
  localparam logic [CW-1:0] LAST = CW'(NB - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [HW-1:0] acc_q, acc_d;

  always_comb begin
    cnt_d    = cnt_q;
    acc_d    = acc_q;
    pkt_done = 1'b0;
    ferr_set = 1'b0;
    if (beat_vld) begin
      if (beat_flag) begin
        ferr_set = (cnt_q != '0);
        acc_d    = HW'(beat_data);
        cnt_d    = CW'(1);
      end else if (cnt_q != '0) begin
        if (cnt_q == LAST) begin
          pkt_done = 1'b1;
          cnt_d    = '0;
        end else begin
          acc_d = {acc_q[HW-BW-1:0], beat_data};
          cnt_d = cnt_q + CW'(1);
        end
      end
    end
  end

  assign pkt = {acc_q, beat_data};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      acc_q <= '0;
    end else if (beat_vld) begin
      cnt_q <= cnt_d;
      acc_q <= acc_d;
    end
  end

  // R3: beat counter never passes the last beat slot
  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  // R10: a stray unflagged beat in idle leaves the receiver idle
  a_r10_stray_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && beat_vld && !beat_flag) |=> (cnt_q == '0));

  // R11: an idle cycle leaves the partial packet untouched
  a_r11_gap_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !beat_vld |=> ($stable(cnt_q) && $stable(acc_q)));
endmodule

// File: rtl/cmdrx_id_latch.sv
module cmdrx_id_latch
  import cmdrx_pkg::*;
#(
  parameter int unsigned IW = ID_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] id_strap,
  output logic [IW-1:0] id_q,
  output logic          id_ok
);
  logic          cap_en;
  logic [IW-1:0] id_d;

  always_comb begin
    cap_en = !id_ok;
    id_d   = id_strap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q  <= '0;
      id_ok <= 1'b0;
    end else if (cap_en) begin
      id_q  <= id_d;
      id_ok <= 1'b1;
    end
  end

  // R2: once captured, the ID never changes until the next reset
  a_r2_id_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    id_ok |=> (id_ok && $stable(id_q)));
endmodule

// File: rtl/cmdrx_decode.sv
module cmdrx_decode
  import cmdrx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pkt_done,
  input  logic [PKT_W-1:0]  pkt,
  input  logic              ferr_set,
  input  logic [ID_W-1:0]   id_q,
  input  logic              id_ok,
  output logic              cmd_vld,
  output logic [OP_W-1:0]   cmd_op,
  output logic [BLEN_W-1:0] cmd_blen,
  output logic              cmd_dclk,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              frame_err
);
  logic              hit;
  logic [OP_W-1:0]   op_d;
  logic [BLEN_W-1:0] blen_d;
  logic              dclk_d;
  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    hit    = pkt_done && id_ok && (pkt[PKT_W-1:ID_LSB] == id_q);
    op_d   = pkt[OP_LSB +: OP_W];
    blen_d = pkt[B8_BIT] ? BLEN_W'(8) : BLEN_W'(4);
    dclk_d = pkt[DCK_BIT];
    addr_d = pkt[ADDR_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_vld   <= 1'b0;
      frame_err <= 1'b0;
    end else begin
      cmd_vld   <= hit;
      frame_err <= ferr_set;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_op   <= '0;
      cmd_blen <= BLEN_W'(4);
      cmd_dclk <= 1'b0;
      cmd_addr <= '0;
    end else if (hit) begin
      cmd_op   <= op_d;
      cmd_blen <= blen_d;
      cmd_dclk <= dclk_d;
      cmd_addr <= addr_d;
    end
  end

  // R4: a delivered command lasts a single cycle
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld |=> !cmd_vld);

  // R8: a delivered command always follows a completed packet
  a_r8_from_done: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld |-> $past(pkt_done));

  // R6: burst length is one of the two legal sizes
  a_r6_blen_legal: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld |-> (cmd_blen == BLEN_W'(4) || cmd_blen == BLEN_W'(8)));

  // R9: a framing error and a delivery never coincide
  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_vld && frame_err));
endmodule

// File: rtl/cmdrx_top.sv
module cmdrx_top
  import cmdrx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ID_W-1:0]   id_strap,
  input  logic              beat_vld,
  input  logic              beat_flag,
  input  logic [BEAT_W-1:0] beat_data,
  output logic              cmd_vld,
  output logic [OP_W-1:0]   cmd_op,
  output logic [BLEN_W-1:0] cmd_blen,
  output logic              cmd_dclk,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              frame_err
);
  logic [1:0]       rst_sync;
  logic             srst_n;
  logic             pkt_done;
  logic [PKT_W-1:0] pkt;
  logic             ferr_set;
  logic [ID_W-1:0]  id_q;
  logic             id_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign srst_n = rst_sync[1];

  cmdrx_assembler #(.BW(BEAT_W), .NB(N_BEATS)) u_asm (
    .clk       (clk),
    .rst_n     (srst_n),
    .beat_vld  (beat_vld),
    .beat_flag (beat_flag),
    .beat_data (beat_data),
    .pkt_done  (pkt_done),
    .pkt       (pkt),
    .ferr_set  (ferr_set)
  );

  cmdrx_id_latch #(.IW(ID_W)) u_id (
    .clk      (clk),
    .rst_n    (srst_n),
    .id_strap (id_strap),
    .id_q     (id_q),
    .id_ok    (id_ok)
  );

  cmdrx_decode u_dec (
    .clk       (clk),
    .rst_n     (srst_n),
    .pkt_done  (pkt_done),
    .pkt       (pkt),
    .ferr_set  (ferr_set),
    .id_q      (id_q),
    .id_ok     (id_ok),
    .cmd_vld   (cmd_vld),
    .cmd_op    (cmd_op),
    .cmd_blen  (cmd_blen),
    .cmd_dclk  (cmd_dclk),
    .cmd_addr  (cmd_addr),
    .frame_err (frame_err)
  );

  // R9: a framing error is always caused by a flagged beat one cycle earlier
  a_r9_ferr_cause: assert property (@(posedge clk) disable iff (!srst_n)
    frame_err |-> $past(beat_vld && beat_flag));

  // R1: outputs are quiet while reset is held
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> (!cmd_vld && !frame_err));
endmodule

// File: tb/cmdrx_top_bench.sv
module cmdrx_top_bench;
  localparam logic [8:0] ID_A = 9'h15A;
  localparam logic [8:0] ID_B = 9'h0C3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [8:0]  id_strap;
  logic        beat_vld, beat_flag;
  logic [9:0]  beat_data;
  logic        cmd_vld, cmd_dclk, frame_err;
  logic [3:0]  cmd_op, cmd_blen;
  logic [24:0] cmd_addr;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  string stage = "R1";

  always #2 clk = ~clk;

  cmdrx_top u_cmdrx_top (
    .clk(clk), .rst_n(rst_n), .id_strap(id_strap),
    .beat_vld(beat_vld), .beat_flag(beat_flag), .beat_data(beat_data),
    .cmd_vld(cmd_vld), .cmd_op(cmd_op), .cmd_blen(cmd_blen),
    .cmd_dclk(cmd_dclk), .cmd_addr(cmd_addr), .frame_err(frame_err)
  );

  // behavioural reference
  int          m_cnt;
  logic [39:0] m_acc;
  logic        e_vld, e_err, e_dc;
  logic [3:0]  e_op, e_blen;
  logic [24:0] e_addr;
  int          n_hit_exp = 0;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_cnt = 0; m_acc = '0; e_vld = 0; e_err = 0;
    end else begin
      e_vld = 0; e_err = 0;
      if (beat_vld) begin
        if (beat_flag) begin
          if (m_cnt != 0) e_err = 1;
          m_acc = {30'b0, beat_data};
          m_cnt = 1;
        end else if (m_cnt != 0) begin
          m_acc = {m_acc[29:0], beat_data};
          m_cnt++;
          if (m_cnt == 4) begin
            m_cnt = 0;
            if (m_acc[39:31] == ID_A) begin
              e_vld  = 1;
              e_op   = m_acc[30:27];
              e_blen = m_acc[26] ? 4'd8 : 4'd4;
              e_dc   = m_acc[25];
              e_addr = m_acc[24:0];
              n_hit_exp++;
            end
          end
        end
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s [%s] %s actual=%0h expected=%0h at cycle %0d", req, stage, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n === 1'b0) begin
      chk("R1", "cmd_vld in reset", int'(cmd_vld), 0);
      chk("R1", "frame_err in reset", int'(frame_err), 0);
    end else if (rst_n === 1'b1) begin
      chk("R4", "cmd_vld", int'(cmd_vld), int'(e_vld));
      chk("R9", "frame_err", int'(frame_err), int'(e_err));
      if (e_vld) begin
        chk("R5", "cmd_op", int'(cmd_op), int'(e_op));
        chk("R5", "cmd_addr", int'(cmd_addr), int'(e_addr));
        chk("R6", "cmd_blen", int'(cmd_blen), int'(e_blen));
        chk("R7", "cmd_dclk", int'(cmd_dclk), int'(e_dc));
      end
    end
  end

  task automatic beat(input logic f, input logic [9:0] d);
    @(negedge clk);
    beat_vld = 1; beat_flag = f; beat_data = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      beat_vld = 0; beat_flag = 0; beat_data = 10'h3FF;
    end
  endtask

  task automatic send(input logic [8:0] id, input logic [3:0] op, input logic b8,
                      input logic dc, input logic [24:0] ad, input int gap);
    logic [39:0] p;
    p = {id, op, b8, dc, ad};
    for (int b = 0; b < 4; b++) begin
      beat(b == 0, p[39 - 10*b -: 10]);
      if (gap > 0 && b < 3) idle(gap);
    end
  endtask

  initial begin
    int hits_before;
    rst_n = 0; id_strap = ID_A;
    beat_vld = 0; beat_flag = 0; beat_data = '0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    idle(6);

    stage = "R3"; send(ID_A, 4'h3, 1'b0, 1'b0, 25'h0ABCDE, 0); idle(2);
    stage = "R6"; send(ID_A, 4'hC, 1'b1, 1'b1, 25'h1FFFFFF, 0); idle(2);
    stage = "R7"; send(ID_A, 4'h0, 1'b0, 1'b1, 25'h0000001, 0); idle(2);
    stage = "R11"; send(ID_A, 4'h9, 1'b1, 1'b0, 25'h1234567, 3); idle(2);

    stage = "R8";
    hits_before = n_hit_exp;
    send(ID_A ^ 9'h100, 4'h5, 1'b1, 1'b1, 25'h0F0F0F0, 0);
    send(ID_A ^ 9'h001, 4'h6, 1'b0, 1'b0, 25'h1111111, 0); idle(2);
    chk("R8", "expected deliveries after foreign IDs", n_hit_exp, hits_before);

    stage = "R10";
    beat(0, ID_A[8:0] + 10'h0); beat(0, 10'h2AA); beat(0, 10'h155); beat(0, 10'h000);
    idle(2);
    send(ID_A, 4'h7, 1'b0, 1'b1, 25'h0055AA5, 0); idle(2);

    stage = "R9";
    beat(1, {ID_A, 1'b1}); beat(0, 10'h123);
    send(ID_A, 4'hA, 1'b1, 1'b0, 25'h0A0A0A0, 0); idle(2);
    beat(1, {ID_A, 1'b0}); beat(0, 10'h3FF); beat(0, 10'h3FF);
    send(ID_A, 4'hB, 1'b0, 1'b0, 25'h1C3C3C3, 0); idle(2);
    beat(1, 10'h000); idle(2);
    send(ID_A, 4'h1, 1'b1, 1'b1, 25'h0000000, 1); idle(2);

    stage = "R2";
    id_strap = ID_B;
    idle(2);
    hits_before = n_hit_exp;
    send(ID_B, 4'h2, 1'b0, 1'b0, 25'h0777777, 0); idle(2);
    chk("R2", "deliveries for new strap value", n_hit_exp, hits_before);
    send(ID_A, 4'hE, 1'b1, 1'b0, 25'h1800001, 0); idle(2);

    stage = "R4";
    for (int k = 0; k < 12; k++)
      send((k % 3 == 2) ? ID_B : ID_A, 4'(k), k[0], k[1], 25'(k * 32'h0013579B), 0);
    idle(4);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule